// File: doc/BRIEF.md
# Queue Pair Pointer Tracker

This block keeps the ring pointers for a small set of queue pairs in a storage-style host interface. Every pair has a submission ring, which the host fills and the controller drains, and a completion ring, which the controller fills and the host drains. The host moves its own side of each ring by writing doorbells. The controller moves the other side with two strobes: one when it fetches a command and one when it posts a completion. From these pointers the block reports, for each queue, whether the submission ring is empty, whether the completion ring is full, and the current completion phase tag.

Doorbells arrive on a byte-addressed register port. The spacing between doorbell slots is a power of two chosen by a stride setting. Slots alternate between the two sides: an even slot belongs to a submission ring and an odd slot to a completion ring. A management port creates and deletes queues. A configuration input limits which queue numbers are accepted at all. A read port shows all four pointers of one queue pair. Illegal doorbells and refused completions each raise a one-cycle error pulse.

Top module: `qpt_tracker`

## Requirements
- R1: After reset no queue is ready, the empty and full vectors are zero, every phase bit is 1, both error pulses are low and every pointer reads 0.
- R2: A create command loads the ring size and clears the head and tail. For a completion ring it also sets the phase to 1. A delete command drops the ready flag. A queue is ready only while it is created and its number is at most `cfg_nr_io`.
- R3: A doorbell slot is 4 << `cfg_stride` bytes wide. The submission tail of queue q is at byte offset 2q slots, and the completion head of queue q is at 2q+1 slots. An accepted write shows on the read port one cycle later.
- R4: A doorbell write is rejected when it hits a misaligned offset, a queue number that is NQ or more, a queue number above `cfg_nr_io`, a queue that is not ready, or a value at or above the ring size. A rejected write raises `db_err` for exactly one cycle and changes no pointer.
- R5: A fetch strobe on a ready, non-empty submission ring moves the head to head+1 modulo the size. A fetch strobe on an empty or non-ready ring changes nothing.
- R6: `sq_empty[q]` is 1 exactly when queue q is ready and its submission head equals the tail the host last wrote.
- R7: An accepted completion post moves the tail to tail+1 modulo the size. When the tail wraps from size-1 to 0, the phase bit of that queue inverts.
- R8: `cq_full[q]` is 1 exactly when queue q is ready and (tail+1) mod size equals the head the host wrote.
- R9: A post strobe on a full or non-ready completion ring leaves the tail unchanged and raises `post_err` for one cycle.
- R10: When a doorbell and a controller strobe hit the same ring in the same cycle, the new doorbell value is used to decide empty or full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_stride | input | SW | Doorbell slot is 4 << cfg_stride bytes |
| cfg_nr_io | input | log2(NQ) | Highest queue number accepted |
| mgmt_create | input | 1 | Create the selected queue |
| mgmt_delete | input | 1 | Delete the selected queue |
| mgmt_side | input | 1 | 0 selects the submission ring, 1 the completion ring |
| mgmt_qid | input | log2(NQ) | Queue number for create or delete |
| mgmt_size | input | PW | Ring size loaded on create |
| db_wr | input | 1 | Doorbell write strobe |
| db_addr | input | AW | Doorbell byte offset |
| db_data | input | PW | Doorbell value (new tail or new head) |
| cons_vld | input | 1 | Controller fetched a command |
| cons_qid | input | log2(NQ) | Queue of the fetched command |
| post_vld | input | 1 | Controller wants to post a completion |
| post_qid | input | log2(NQ) | Queue of the completion |
| rd_qid | input | log2(NQ) | Queue shown on the read port |
| rd_sq_head | output | PW | Submission head of rd_qid |
| rd_sq_tail | output | PW | Submission tail of rd_qid |
| rd_cq_head | output | PW | Completion head of rd_qid |
| rd_cq_tail | output | PW | Completion tail of rd_qid |
| sq_ready | output | NQ | Submission ring ready, per queue |
| cq_ready | output | NQ | Completion ring ready, per queue |
| sq_empty | output | NQ | Submission ring empty, per queue |
| cq_full | output | NQ | Completion ring full, per queue |
| cq_phase | output | NQ | Completion phase tag, per queue |
| db_err | output | 1 | One-cycle pulse for a rejected doorbell |
| post_err | output | 1 | One-cycle pulse for a refused post |

## Verification
The case that needs care is a host doorbell and a controller strobe landing on the same ring in the same cycle. This is a completion head write together with a post, or a submission tail write together with a fetch. The bench first brings a completion ring to full. It then moves the head and posts in the same cycle, and expects the post to be accepted. Next it writes a head that makes the ring full, again together with a post, and expects a refusal. For the submission side it empties the ring, then writes a new tail and fetches in one cycle, and expects the head to advance. Each verdict is read from `post_err`, the read port and the status vectors one cycle later. The expected values come from a model that applies the doorbell before it judges the strobe.

// File: rtl/qpt_pkg.sv
package qpt_pkg;
  typedef enum logic {Q_SUB = 1'b0, Q_CMP = 1'b1} qpt_side_e;

  // log2 of the doorbell slot width in bytes for a given stride setting
  function automatic int db_shift(input int stride);
    return 2 + stride;
  endfunction
endpackage

// File: rtl/qpt_db_decode.sv
module qpt_db_decode
  import qpt_pkg::*;
#(
  parameter int NQ = 8,
  parameter int QW = 3,
  parameter int AW = 10,
  parameter int SW = 2
) (
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] stride,
  input  logic [QW-1:0] nr_io,
  output logic          hit_ok,
  output logic [QW-1:0] qid,
  output qpt_side_e     side
);
  int            sh;
  logic [AW-1:0] mask;
  logic [AW-1:0] idx;
  logic [AW-1:0] qwide;
  logic          aligned;
  logic          in_range;

  always_comb begin
    sh       = db_shift(int'(stride));
    mask     = (AW'(1) << sh) - AW'(1);
    aligned  = (addr & mask) == '0;
    idx      = addr >> sh;
    side     = qpt_side_e'(idx[0]);
    qwide    = idx >> 1;
    qid      = QW'(qwide);
    in_range = (qwide < AW'(NQ)) && (QW'(qwide) <= nr_io);
    hit_ok   = aligned && in_range;
  end
endmodule

// File: rtl/qpt_sq_slot.sv
module qpt_sq_slot #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_range,
  input  logic          create,
  input  logic          remove,
  input  logic [PW-1:0] size_in,
  input  logic          tdb_hit,
  input  logic [PW-1:0] tdb_val,
  input  logic          cons,
  output logic          ready,
  output logic          empty,
  output logic          cons_ok,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [PW-1:0] size
);
  logic          vld_q;
  logic [PW-1:0] eff_tail;

  function automatic logic [PW-1:0] ring_next(input logic [PW-1:0] p, input logic [PW-1:0] n);
    return (p == n - PW'(1)) ? '0 : p + PW'(1);
  endfunction

  assign ready    = vld_q && in_range;
  assign eff_tail = tdb_hit ? tdb_val : tail;
  assign cons_ok  = cons && ready && !create && (head != eff_tail);
  assign empty    = ready && (head == tail);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      size  <= '0;
      head  <= '0;
      tail  <= '0;
    end else if (create) begin
      vld_q <= 1'b1;
      size  <= size_in;
      head  <= '0;
      tail  <= '0;
    end else begin
      if (remove)  vld_q <= 1'b0;
      if (tdb_hit) tail  <= tdb_val;
      if (cons_ok) head  <= ring_next(head, size);
    end
  end
endmodule

// File: rtl/qpt_cq_slot.sv
module qpt_cq_slot #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_range,
  input  logic          create,
  input  logic          remove,
  input  logic [PW-1:0] size_in,
  input  logic          hdb_hit,
  input  logic [PW-1:0] hdb_val,
  input  logic          post,
  output logic          ready,
  output logic          full,
  output logic          post_ok,
  output logic          phase,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [PW-1:0] size
);
  logic          vld_q;
  logic [PW-1:0] eff_head;
  logic [PW-1:0] tail_nx;
  logic          wrap;

  function automatic logic [PW-1:0] ring_next(input logic [PW-1:0] p, input logic [PW-1:0] n);
    return (p == n - PW'(1)) ? '0 : p + PW'(1);
  endfunction

  assign ready    = vld_q && in_range;
  assign tail_nx  = ring_next(tail, size);
  assign wrap     = (tail == size - PW'(1));
  assign eff_head = hdb_hit ? hdb_val : head;
  assign post_ok  = post && ready && !create && (tail_nx != eff_head);
  assign full     = ready && (tail_nx == head);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      size  <= '0;
      head  <= '0;
      tail  <= '0;
      phase <= 1'b1;
    end else if (create) begin
      vld_q <= 1'b1;
      size  <= size_in;
      head  <= '0;
      tail  <= '0;
      phase <= 1'b1;
    end else begin
      if (remove)  vld_q <= 1'b0;
      if (hdb_hit) head  <= hdb_val;
      if (post_ok) begin
        tail <= tail_nx;
        if (wrap) phase <= ~phase;
      end
    end
  end
endmodule

// File: rtl/qpt_tracker.sv
module qpt_tracker
  import qpt_pkg::*;
#(
  parameter int NQ = 8,
  parameter int PW = 8,
  parameter int SW = 2,
  parameter int AW = 10,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] cfg_stride,
  input  logic [QW-1:0] cfg_nr_io,
  input  logic          mgmt_create,
  input  logic          mgmt_delete,
  input  logic          mgmt_side,
  input  logic [QW-1:0] mgmt_qid,
  input  logic [PW-1:0] mgmt_size,
  input  logic          db_wr,
  input  logic [AW-1:0] db_addr,
  input  logic [PW-1:0] db_data,
  input  logic          cons_vld,
  input  logic [QW-1:0] cons_qid,
  input  logic          post_vld,
  input  logic [QW-1:0] post_qid,
  input  logic [QW-1:0] rd_qid,
  output logic [PW-1:0] rd_sq_head,
  output logic [PW-1:0] rd_sq_tail,
  output logic [PW-1:0] rd_cq_head,
  output logic [PW-1:0] rd_cq_tail,
  output logic [NQ-1:0] sq_ready,
  output logic [NQ-1:0] cq_ready,
  output logic [NQ-1:0] sq_empty,
  output logic [NQ-1:0] cq_full,
  output logic [NQ-1:0] cq_phase,
  output logic          db_err,
  output logic          post_err
);
  // named internal events, also watched by the checker
  logic [NQ-1:0][PW-1:0] sq_head_a, sq_tail_a, sq_size_a;
  logic [NQ-1:0][PW-1:0] cq_head_a, cq_tail_a, cq_size_a;
  logic [NQ-1:0]         sq_cons_ok, cq_post_ok, sq_tdb, cq_hdb;

  logic          dec_ok;
  logic [QW-1:0] dec_qid;
  qpt_side_e     dec_side;
  logic          tgt_ready;
  logic [PW-1:0] tgt_size;
  logic          db_ok;

  qpt_db_decode #(.NQ(NQ), .QW(QW), .AW(AW), .SW(SW)) u_dec (
    .addr   (db_addr),
    .stride (cfg_stride),
    .nr_io  (cfg_nr_io),
    .hit_ok (dec_ok),
    .qid    (dec_qid),
    .side   (dec_side)
  );

  always_comb begin
    if (dec_side == Q_CMP) begin
      tgt_ready = cq_ready[dec_qid];
      tgt_size  = cq_size_a[dec_qid];
    end else begin
      tgt_ready = sq_ready[dec_qid];
      tgt_size  = sq_size_a[dec_qid];
    end
    db_ok = db_wr && dec_ok && tgt_ready && (db_data < tgt_size);
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    localparam logic [QW-1:0] QID = QW'(q);
    logic in_rng;
    logic sel_mgmt;
    assign in_rng   = (QID <= cfg_nr_io);
    assign sel_mgmt = (mgmt_qid == QID);
    assign sq_tdb[q] = db_ok && (dec_side == Q_SUB) && (dec_qid == QID);
    assign cq_hdb[q] = db_ok && (dec_side == Q_CMP) && (dec_qid == QID);

    qpt_sq_slot #(.PW(PW)) u_sq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_range (in_rng),
      .create   (mgmt_create && !mgmt_side && sel_mgmt),
      .remove   (mgmt_delete && !mgmt_side && sel_mgmt),
      .size_in  (mgmt_size),
      .tdb_hit  (sq_tdb[q]),
      .tdb_val  (db_data),
      .cons     (cons_vld && (cons_qid == QID)),
      .ready    (sq_ready[q]),
      .empty    (sq_empty[q]),
      .cons_ok  (sq_cons_ok[q]),
      .head     (sq_head_a[q]),
      .tail     (sq_tail_a[q]),
      .size     (sq_size_a[q])
    );

    qpt_cq_slot #(.PW(PW)) u_cq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_range (in_rng),
      .create   (mgmt_create && mgmt_side && sel_mgmt),
      .remove   (mgmt_delete && mgmt_side && sel_mgmt),
      .size_in  (mgmt_size),
      .hdb_hit  (cq_hdb[q]),
      .hdb_val  (db_data),
      .post     (post_vld && (post_qid == QID)),
      .ready    (cq_ready[q]),
      .full     (cq_full[q]),
      .post_ok  (cq_post_ok[q]),
      .phase    (cq_phase[q]),
      .head     (cq_head_a[q]),
      .tail     (cq_tail_a[q]),
      .size     (cq_size_a[q])
    );
  end

  assign rd_sq_head = sq_head_a[rd_qid];
  assign rd_sq_tail = sq_tail_a[rd_qid];
  assign rd_cq_head = cq_head_a[rd_qid];
  assign rd_cq_tail = cq_tail_a[rd_qid];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_err   <= 1'b0;
      post_err <= 1'b0;
    end else begin
      db_err   <= db_wr && !db_ok;
      post_err <= post_vld && !(|cq_post_ok);
    end
  end
endmodule

// File: rtl/qpt_tracker_chk.sv
module qpt_tracker_chk #(
  parameter int NQ = 8,
  parameter int PW = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mgmt_create,
  input logic                  db_err,
  input logic                  post_err,
  input logic [NQ-1:0][PW-1:0] sq_head_a,
  input logic [NQ-1:0][PW-1:0] sq_tail_a,
  input logic [NQ-1:0][PW-1:0] sq_size_a,
  input logic [NQ-1:0][PW-1:0] cq_head_a,
  input logic [NQ-1:0][PW-1:0] cq_tail_a,
  input logic [NQ-1:0][PW-1:0] cq_size_a,
  input logic [NQ-1:0]         sq_cons_ok,
  input logic [NQ-1:0]         cq_post_ok,
  input logic [NQ-1:0]         cq_hdb,
  input logic [NQ-1:0]         cq_full,
  input logic [NQ-1:0]         cq_phase
);
  // R4: a rejected doorbell leaves every host-side pointer as it was
  a_r4_reject_keeps_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
    (db_err && !$past(mgmt_create)) |-> ($stable(sq_tail_a) && $stable(cq_head_a)));

  // R9: a refused post leaves every completion tail as it was
  a_r9_refuse_keeps_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (post_err && !$past(mgmt_create)) |-> $stable(cq_tail_a));

  for (genvar q = 0; q < NQ; q++) begin : g_chk
    // R8: an accepted post never meets a full ring unless the head moved in that cycle
    a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (cq_post_ok[q] && !cq_hdb[q]) |-> !cq_full[q]);

    // R7: a post from the last slot inverts the phase tag
    a_r7_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (cq_post_ok[q] && (cq_tail_a[q] == cq_size_a[q] - PW'(1)))
      |=> (cq_phase[q] != $past(cq_phase[q])));

    // R5: an accepted fetch steps the head by one around the ring
    a_r5_head_step: assert property (@(posedge clk) disable iff (!rst_n)
      sq_cons_ok[q] |=> (sq_head_a[q] ==
        (($past(sq_head_a[q]) == $past(sq_size_a[q]) - PW'(1)) ? '0 : $past(sq_head_a[q]) + PW'(1))));

    // R5: without an accepted fetch or a create the head holds
    a_r5_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sq_cons_ok[q] && !mgmt_create) |=> $stable(sq_head_a[q]));
  end
endmodule

bind qpt_tracker qpt_tracker_chk #(.NQ(NQ), .PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mgmt_create (mgmt_create),
  .db_err      (db_err),
  .post_err    (post_err),
  .sq_head_a   (sq_head_a),
  .sq_tail_a   (sq_tail_a),
  .sq_size_a   (sq_size_a),
  .cq_head_a   (cq_head_a),
  .cq_tail_a   (cq_tail_a),
  .cq_size_a   (cq_size_a),
  .sq_cons_ok  (sq_cons_ok),
  .cq_post_ok  (cq_post_ok),
  .cq_hdb      (cq_hdb),
  .cq_full     (cq_full),
  .cq_phase    (cq_phase)
);

// File: tb/test_qpt_tracker.sv
module test_qpt_tracker;
  localparam int NQ = 8;
  localparam int PW = 8;
  localparam int SW = 2;
  localparam int AW = 10;
  localparam int QW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] cfg_stride = '0;
  logic [QW-1:0] cfg_nr_io = 3'd3;
  logic          mgmt_create = 1'b0, mgmt_delete = 1'b0, mgmt_side = 1'b0;
  logic [QW-1:0] mgmt_qid = '0;
  logic [PW-1:0] mgmt_size = '0;
  logic          db_wr = 1'b0;
  logic [AW-1:0] db_addr = '0;
  logic [PW-1:0] db_data = '0;
  logic          cons_vld = 1'b0, post_vld = 1'b0;
  logic [QW-1:0] cons_qid = '0, post_qid = '0, rd_qid = '0;
  logic [PW-1:0] rd_sq_head, rd_sq_tail, rd_cq_head, rd_cq_tail;
  logic [NQ-1:0] sq_ready, cq_ready, sq_empty, cq_full, cq_phase;
  logic          db_err, post_err;

  always #2 clk = ~clk;

  qpt_tracker #(.NQ(NQ), .PW(PW), .SW(SW), .AW(AW)) i_qpt_tracker (.*);

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  int g_s = 0;
  int g_nr = 3;
  int m_ssz[NQ], m_sh[NQ], m_st[NQ], m_csz[NQ], m_ch[NQ], m_ct[NQ];
  bit m_sv[NQ], m_cv[NQ], m_ph[NQ];

  function automatic int nx(input int p, input int n);
    return (p == n - 1) ? 0 : p + 1;
  endfunction
  function automatic int sq_off(input int q, input int s);
    return (2 * q) * (4 << s);
  endfunction
  function automatic int cq_off(input int q, input int s);
    return (2 * q + 1) * (4 << s);
  endfunction
  function automatic bit s_rdy(input int q);
    return m_sv[q] && q <= g_nr;
  endfunction
  function automatic bit c_rdy(input int q);
    return m_cv[q] && q <= g_nr;
  endfunction

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model of a doorbell write; returns 1 when it should be accepted
  function automatic bit db_model(input int addr, input int data);
    int sh, idx, q;
    sh = 2 + g_s;
    if (addr % (1 << sh) != 0) return 0;
    idx = addr >> sh;
    q = idx / 2;
    if (q >= NQ || q > g_nr) return 0;
    if (idx % 2 == 0) begin
      if (!s_rdy(q) || data >= m_ssz[q]) return 0;
      m_st[q] = data;
    end else begin
      if (!c_rdy(q) || data >= m_csz[q]) return 0;
      m_ch[q] = data;
    end
    return 1;
  endfunction

  function automatic void cons_model(input int q);
    if (q < NQ && s_rdy(q) && m_sh[q] != m_st[q]) m_sh[q] = nx(m_sh[q], m_ssz[q]);
  endfunction

  function automatic bit post_model(input int q);
    if (!(q < NQ && c_rdy(q)) || nx(m_ct[q], m_csz[q]) == m_ch[q]) return 1;
    if (m_ct[q] == m_csz[q] - 1) m_ph[q] = ~m_ph[q];
    m_ct[q] = nx(m_ct[q], m_csz[q]);
    return 0;
  endfunction

  task automatic act(input bit w, input int addr, input int data,
                     input bit c, input int cq, input bit p, input int pq);
    db_wr = w; db_addr = AW'(addr); db_data = PW'(data);
    cons_vld = c; cons_qid = QW'(cq); post_vld = p; post_qid = QW'(pq);
    @(negedge clk);
    db_wr = 1'b0; cons_vld = 1'b0; post_vld = 1'b0;
  endtask

  task automatic dbw(input string tag, input int addr, input int data);
    bit ok;
    ok = db_model(addr, data);
    act(1, addr, data, 0, 0, 0, 0);
    chk_eq({tag, " db_err"}, int'(db_err), int'(!ok));
  endtask

  task automatic mgmt(input bit cr, input bit dl, input bit side, input int q, input int sz);
    mgmt_create = cr; mgmt_delete = dl; mgmt_side = side;
    mgmt_qid = QW'(q); mgmt_size = PW'(sz);
    @(negedge clk);
    mgmt_create = 1'b0; mgmt_delete = 1'b0;
    if (cr) begin
      if (!side) begin m_sv[q] = 1; m_ssz[q] = sz; m_sh[q] = 0; m_st[q] = 0; end
      else begin m_cv[q] = 1; m_csz[q] = sz; m_ch[q] = 0; m_ct[q] = 0; m_ph[q] = 1; end
    end else if (dl) begin
      if (!side) m_sv[q] = 0; else m_cv[q] = 0;
    end
  endtask

  task automatic chk_q(input string tag, input int q);
    rd_qid = QW'(q);
    #1;
    chk_eq({tag, " sq head"}, int'(rd_sq_head), m_sh[q]);
    chk_eq({tag, " sq tail"}, int'(rd_sq_tail), m_st[q]);
    chk_eq({tag, " cq head"}, int'(rd_cq_head), m_ch[q]);
    chk_eq({tag, " cq tail"}, int'(rd_cq_tail), m_ct[q]);
    chk_eq({tag, " R6 empty"}, int'(sq_empty[q]), int'(s_rdy(q) && m_sh[q] == m_st[q]));
    chk_eq({tag, " R8 full"}, int'(cq_full[q]), int'(c_rdy(q) && nx(m_ct[q], m_csz[q]) == m_ch[q]));
    chk_eq({tag, " R7 phase"}, int'(cq_phase[q]), int'(m_ph[q]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit refused;
    for (int q = 0; q < NQ; q++) begin
      m_sv[q] = 0; m_cv[q] = 0; m_ph[q] = 1;
      m_ssz[q] = 0; m_csz[q] = 0; m_sh[q] = 0; m_st[q] = 0; m_ch[q] = 0; m_ct[q] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk_eq("R1 sq_ready", int'(sq_ready), 0);
    chk_eq("R1 cq_ready", int'(cq_ready), 0);
    chk_eq("R1 sq_empty", int'(sq_empty), 0);
    chk_eq("R1 cq_full", int'(cq_full), 0);
    chk_eq("R1 cq_phase", int'(cq_phase), 255);
    chk_eq("R1 db_err", int'(db_err), 0);
    chk_eq("R1 post_err", int'(post_err), 0);
    chk_q("R1", 0);
    @(negedge clk);

    // R2 create queues 0..3 plus an out-of-range queue 5
    for (int q = 0; q < 4; q++) begin
      mgmt(1, 0, 0, q, 3 + q);
      mgmt(1, 0, 1, q, 3 + q);
    end
    mgmt(1, 0, 0, 5, 4);
    mgmt(1, 0, 1, 5, 4);
    chk_eq("R2 sq_ready", int'(sq_ready), 15);
    chk_eq("R2 cq_ready", int'(cq_ready), 15);
    chk_eq("R2 sq_empty", int'(sq_empty), 15);
    chk_eq("R2 cq_full", int'(cq_full), 0);
    chk_q("R2", 2);

    // R3 doorbell layout sweep over every stride
    for (int s = 0; s < 4; s++) begin
      g_s = s;
      cfg_stride = SW'(s);
      for (int q = 0; q < 4; q++) begin
        dbw("R3 sq", sq_off(q, s), (s + q) % (3 + q));
        chk_q("R3 sq", q);
        dbw("R3 cq", cq_off(q, s), (s + 2 * q + 1) % (3 + q));
        chk_q("R3 cq", q);
      end
    end

    // R4 rejected doorbells at stride 1
    g_s = 1;
    cfg_stride = SW'(1);
    dbw("R4 misaligned", sq_off(1, 1) + 4, 1);
    chk_q("R4 misaligned", 1);
    dbw("R4 above nr_io", sq_off(4, 1), 0);
    dbw("R4 created out of range", cq_off(5, 1), 1);
    dbw("R4 beyond NQ", sq_off(8, 1), 0);
    dbw("R4 value at size", sq_off(2, 1), 5);
    chk_q("R4 value at size", 2);
    act(0, 0, 0, 0, 0, 0, 0);
    chk_eq("R4 pulse drops", int'(db_err), 0);

    // R5/R6 fetch sweep on queue 1 over every tail value
    for (int t = 0; t < 4; t++) begin
      dbw("R5 tail", sq_off(1, 1), t);
      for (int k = 0; k < 5; k++) begin
        cons_model(1);
        act(0, 0, 0, 1, 1, 0, 0);
        chk_q("R5 fetch", 1);
      end
    end
    act(0, 0, 0, 1, 6, 0, 0);
    chk_q("R5 fetch on uncreated", 1);

    // R7/R8/R9 post sweep on queue 2 (size 5)
    for (int i = 0; i < 30; i++) begin
      refused = post_model(2);
      act(0, 0, 0, 0, 0, 1, 2);
      chk_eq("R9 post_err", int'(post_err), int'(refused));
      chk_q("R7 post", 2);
      if (refused) dbw("R8 head", cq_off(2, 1), (m_ch[2] + 2) % 5);
    end
    refused = post_model(4);
    act(0, 0, 0, 0, 0, 1, 4);
    chk_eq("R9 post to invalid", int'(post_err), int'(refused));

    // R10 doorbell and strobe in the same cycle
    dbw("R10 fill", cq_off(3, 1), nx(m_ct[3], 6));
    chk_eq("R10 full before", int'(cq_full[3]), 1);
    begin
      int nh;
      bit okd;
      nh = (m_ch[3] + 1) % 6;
      okd = db_model(cq_off(3, 1), nh);
      refused = post_model(3);
      act(1, cq_off(3, 1), nh, 0, 0, 1, 3);
      chk_eq("R10 freed post accepted", int'(post_err), int'(refused));
      chk_eq("R10 freed db ok", int'(db_err), int'(!okd));
      chk_q("R10 freed", 3);
      nh = nx(m_ct[3], 6);
      okd = db_model(cq_off(3, 1), nh);
      refused = post_model(3);
      act(1, cq_off(3, 1), nh, 0, 0, 1, 3);
      chk_eq("R10 filled post refused", int'(post_err), int'(refused));
      chk_q("R10 filled", 3);
      dbw("R10 empty sq", sq_off(3, 1), m_sh[3]);
      nh = (m_sh[3] + 2) % 6;
      okd = db_model(sq_off(3, 1), nh);
      cons_model(3);
      act(1, sq_off(3, 1), nh, 1, 3, 0, 0);
      chk_q("R10 fetch with tail", 3);
    end

    // R2 delete then recreate
    mgmt(0, 1, 1, 1, 0);
    chk_eq("R2 delete ready", int'(cq_ready), 13);
    chk_q("R2 deleted", 1);
    dbw("R2 doorbell to deleted", cq_off(1, 1), 0);
    mgmt(1, 0, 1, 1, 3);
    chk_eq("R2 recreate ready", int'(cq_ready), 15);
    chk_q("R2 recreated", 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule